// File: doc/BRIEF.md
# Ring Event Interrupt Status Aggregator

This block gathers per-channel completion and overflow events from a multi-channel DMA host engine and turns them into one interrupt line plus a set of packed 32-bit status words that software reads. Each channel can report three kinds of event: transmit done, receive done and receive overflow. Each event is caught in a sticky status bit. The bits of all channels are laid end to end across as many status words as needed. Each status word is cleared by the same access that reads it.

A separate enable store, with one receive bit and one transmit bit per channel, selects which channels may interrupt. A receive overflow interrupts whenever its channel's receive enable is set. Once the interrupt line has fired, the block holds it off until software has read every status word again. This includes words that only hold bits for disabled channels. An optional auto-clear mode instead wipes all status when the interrupt is taken and keeps the block armed. A read-only field reports the channel count.

The register port is a simple single-cycle interface. Read data is valid combinationally in the cycle of the read. The clear and every write take effect at the following clock edge.

Top module: `ring_irq_agg`

## Requirements
- R1: After reset every status bit and every enable bit is zero, auto-clear is off, the interrupt output is low and the block is armed (every status word counts as already read).
- R2: Status bit positions across the concatenated words: transmit-done of channel c is bit c, receive-done is bit NUM_CH+c, and receive-overflow is bit 2*NUM_CH+c. Bit k lives in word k/32, bit k%32, and word w is read at address w. There are (31+3*NUM_CH)/32 words, and unused bits read zero.
- R3: A read of a status word returns its contents and clears that word at the next edge. Other words are not changed.
- R4: An event that arrives in the same cycle as a read of its word is not lost. The read returns the old contents and the bit is set afterwards.
- R5: Enable bits sit at address 0x40+j. Receive enable of channel c is bit c and transmit enable is bit NUM_CH+c of the concatenated enable words. There are (31+2*NUM_CH)/32 words. Bits beyond 2*NUM_CH and addresses beyond the last enable word read zero and ignore writes.
- R6: While armed, the interrupt output is high exactly when some set status bit is enabled. A transmit-done bit needs its transmit enable. Receive-done and receive-overflow bits both need the receive enable.
- R7: With auto-clear off, a cycle in which the interrupt is high disarms the block. The interrupt stays low until each status word has been read in a later cycle. A status read made in the firing cycle itself does not count.
- R8: Bit 0 at address 0x80 selects auto-clear and reads back. With it set, a cycle in which the interrupt is high clears all status bits at the next edge, except bits for events in that same cycle, and the block stays armed.
- R9: Address 0x81 reads NUM_CH in bits [10:0]. Other unmapped addresses read zero. Writes to status words have no effect, and read data is zero when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txDoneEvt | input | NUM_CH | One-cycle transmit-done event per channel |
| rxDoneEvt | input | NUM_CH | One-cycle receive-done event per channel |
| rxOvfEvt | input | NUM_CH | One-cycle receive-overflow event per channel |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read is destructive for status words) |
| regAddr | input | 8 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the read cycle |
| irq | output | 1 | Interrupt output |

## Verification
The bench first drives single events on chosen channels. These events land in the first word, straddle the word boundary, or fall in the second word, which separates a wrong packing offset from a wrong word split. It then overlaps an event with a read of the same word, and tries enables that mismatch the event kind (a transmit event under a receive-only enable), which tells the overflow-follows-receive rule apart from a plain per-bit mask. Directed read orders then show that rearming waits for the last word and not the first, and that words holding only disabled channels still count. A long stretch of sparse pseudo-random events, reads, enable writes and mode flips follows, compared every clock against a behavioural model. It reaches the rare overlaps: a read in the firing cycle, and a mode change while disarmed.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;
  localparam int RegAddrW = 8;
  localparam int RegDataW = 32;
  localparam int WordIdxW = 6;

  localparam logic [1:0] RegionStatus = 2'b00;
  localparam logic [1:0] RegionEnable = 2'b01;
  localparam logic [1:0] RegionMisc   = 2'b10;

  localparam logic [WordIdxW-1:0] MiscMode = 6'd0;
  localparam logic [WordIdxW-1:0] MiscInfo = 6'd1;

  // Strobes from control to datapath
  typedef struct packed {
    logic                statusRead;
    logic                enableWrite;
    logic                clearAll;
    logic [WordIdxW-1:0] wordIdx;
  } ringStrobe_t;
endpackage

// File: rtl/ring_irq_ctrl.sv
module ring_irq_ctrl
  import ring_irq_pkg::*;
#(
  parameter int NUM_STAT_WORDS = 2,
  parameter int NUM_EN_WORDS   = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [RegAddrW-1:0] regAddr,
  input  logic                regWrBit0,
  input  logic                pending,
  output ringStrobe_t         strobe,
  output logic                autoClear,
  output logic                irq
);
  logic [1:0]          region;
  logic [WordIdxW-1:0] wordIdx;
  logic [NUM_STAT_WORDS-1:0] readSeen;
  logic armed;
  logic fire;
  logic statusHit;
  logic enableHit;
  logic modeWrite;

  assign region  = regAddr[RegAddrW-1 -: 2];
  assign wordIdx = regAddr[WordIdxW-1:0];

  assign statusHit = regRdEn && (region == RegionStatus) && (int'(wordIdx) < NUM_STAT_WORDS);
  assign enableHit = regWrEn && (region == RegionEnable) && (int'(wordIdx) < NUM_EN_WORDS);
  assign modeWrite = regWrEn && (region == RegionMisc) && (wordIdx == MiscMode);

  // Armed once every status word has been read since the last firing
  assign armed = &readSeen;
  assign fire  = armed && pending;
  assign irq   = fire;

  assign strobe.statusRead  = statusHit;
  assign strobe.enableWrite = enableHit;
  assign strobe.clearAll    = fire && autoClear;
  assign strobe.wordIdx     = wordIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readSeen  <= '1;
      autoClear <= 1'b0;
    end else begin
      if (modeWrite) autoClear <= regWrBit0;
      if (fire && !autoClear) begin
        readSeen <= '0;
      end else begin
        for (int w = 0; w < NUM_STAT_WORDS; w++) begin
          if (statusHit && (int'(wordIdx) == w)) readSeen[w] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ring_irq_datapath.sv
module ring_irq_datapath
  import ring_irq_pkg::*;
#(
  parameter int NUM_CH         = 12,
  parameter int NUM_STAT_WORDS = 2,
  parameter int NUM_EN_WORDS   = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   txEvt,
  input  logic [NUM_CH-1:0]   rxEvt,
  input  logic [NUM_CH-1:0]   ovfEvt,
  input  ringStrobe_t         strobe,
  input  logic                regRdEn,
  input  logic [RegAddrW-1:0] regAddr,
  input  logic [RegDataW-1:0] regWrData,
  input  logic                autoClear,
  output logic [RegDataW-1:0] regRdData,
  output logic                pending
);
  localparam int STAT_BITS = 3 * NUM_CH;
  localparam int EN_BITS   = 2 * NUM_CH;
  localparam int STAT_W    = NUM_STAT_WORDS * RegDataW;
  localparam int EN_W      = NUM_EN_WORDS * RegDataW;
  localparam logic [EN_W-1:0] EN_MASK = EN_W'({EN_BITS{1'b1}});

  logic [STAT_W-1:0] evtFlat;
  logic [STAT_W-1:0] statQ;
  logic [EN_W-1:0]   enQ;

  assign evtFlat = STAT_W'({ovfEvt, rxEvt, txEvt});

  // Sticky status words, destructive read, event wins over clear
  for (genvar w = 0; w < NUM_STAT_WORDS; w++) begin : g_stat
    logic wordClr;
    assign wordClr = (strobe.statusRead && (int'(strobe.wordIdx) == w)) || strobe.clearAll;
    always_ff @(posedge clk) begin
      if (!rstN) statQ[w*RegDataW +: RegDataW] <= '0;
      else statQ[w*RegDataW +: RegDataW] <=
             (wordClr ? '0 : statQ[w*RegDataW +: RegDataW]) | evtFlat[w*RegDataW +: RegDataW];
    end
  end

  // Enable words
  for (genvar j = 0; j < NUM_EN_WORDS; j++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rstN) enQ[j*RegDataW +: RegDataW] <= '0;
      else if (strobe.enableWrite && (int'(strobe.wordIdx) == j))
        enQ[j*RegDataW +: RegDataW] <= regWrData & EN_MASK[j*RegDataW +: RegDataW];
    end
  end

  logic [NUM_CH-1:0] txSt, rxSt, ovfSt, rxEn, txEn;
  assign txSt  = statQ[NUM_CH-1:0];
  assign rxSt  = statQ[2*NUM_CH-1:NUM_CH];
  assign ovfSt = statQ[STAT_BITS-1:2*NUM_CH];
  assign rxEn  = enQ[NUM_CH-1:0];
  assign txEn  = enQ[EN_BITS-1:NUM_CH];

  assign pending = (|(txSt & txEn)) | (|(rxSt & rxEn)) | (|(ovfSt & rxEn));

  // Read mux
  logic [1:0]          region;
  logic [WordIdxW-1:0] wordIdx;
  logic [RegDataW-1:0] rdMux;
  assign region  = regAddr[RegAddrW-1 -: 2];
  assign wordIdx = regAddr[WordIdxW-1:0];

  always_comb begin
    rdMux = '0;
    case (region)
      RegionStatus: begin
        for (int w = 0; w < NUM_STAT_WORDS; w++)
          if (int'(wordIdx) == w) rdMux = statQ[w*RegDataW +: RegDataW];
      end
      RegionEnable: begin
        for (int j = 0; j < NUM_EN_WORDS; j++)
          if (int'(wordIdx) == j) rdMux = enQ[j*RegDataW +: RegDataW];
      end
      RegionMisc: begin
        if (wordIdx == MiscMode) rdMux = {{(RegDataW-1){1'b0}}, autoClear};
        else if (wordIdx == MiscInfo) rdMux = {{(RegDataW-11){1'b0}}, 11'(NUM_CH)};
      end
      default: rdMux = '0;
    endcase
  end

  assign regRdData = regRdEn ? rdMux : '0;
endmodule

// File: rtl/ring_irq_agg.sv
module ring_irq_agg
  import ring_irq_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   txDoneEvt,
  input  logic [NUM_CH-1:0]   rxDoneEvt,
  input  logic [NUM_CH-1:0]   rxOvfEvt,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [RegAddrW-1:0] regAddr,
  input  logic [RegDataW-1:0] regWrData,
  output logic [RegDataW-1:0] regRdData,
  output logic                irq
);
  localparam int NUM_STAT_WORDS = (31 + 3 * NUM_CH) / 32;
  localparam int NUM_EN_WORDS   = (31 + 2 * NUM_CH) / 32;

  ringStrobe_t strobe;
  logic        pendingLvl;
  logic        autoClearMode;

  ring_irq_ctrl #(
    .NUM_STAT_WORDS(NUM_STAT_WORDS),
    .NUM_EN_WORDS  (NUM_EN_WORDS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrBit0(regWrData[0]),
    .pending  (pendingLvl),
    .strobe   (strobe),
    .autoClear(autoClearMode),
    .irq      (irq)
  );

  ring_irq_datapath #(
    .NUM_CH        (NUM_CH),
    .NUM_STAT_WORDS(NUM_STAT_WORDS),
    .NUM_EN_WORDS  (NUM_EN_WORDS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .txEvt    (txDoneEvt),
    .rxEvt    (rxDoneEvt),
    .ovfEvt   (rxOvfEvt),
    .strobe   (strobe),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .autoClear(autoClearMode),
    .regRdData(regRdData),
    .pending  (pendingLvl)
  );
endmodule

// File: rtl/ring_irq_agg_chk.sv
module ring_irq_agg_chk #(
  parameter int NUM_CH = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              irq,
  input logic              pending,
  input logic              autoClear,
  input logic [NUM_CH-1:0] txEvt,
  input logic [NUM_CH-1:0] rxEvt,
  input logic [NUM_CH-1:0] ovfEvt,
  input logic              regWrEn
);
  logic noEvt;
  assign noEvt = (txEvt == '0) && (rxEvt == '0) && (ovfEvt == '0);

  // R6: interrupt only with an enabled pending bit
  a_r6_irq_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> pending);

  // R7: without auto-clear a firing disarms the block
  a_r7_disarm_after_fire: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !autoClear) |=> !irq);

  // R8: auto-clear empties status when no new event arrives
  a_r8_autoclear_empties: assert property (@(posedge clk) disable iff (!rstN)
    (irq && autoClear && noEvt) |=> !pending);

  // R2: status bits never appear without an event or an enable write
  a_r2_no_spontaneous: assert property (@(posedge clk) disable iff (!rstN)
    (!pending && noEvt && !regWrEn) |=> !pending);
endmodule

bind ring_irq_agg ring_irq_agg_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .irq      (irq),
  .pending  (pendingLvl),
  .autoClear(autoClearMode),
  .txEvt    (txDoneEvt),
  .rxEvt    (rxDoneEvt),
  .ovfEvt   (rxOvfEvt),
  .regWrEn  (regWrEn)
);

// File: tb/ring_irq_agg_tb_top.sv
module ring_irq_agg_tb_top;
  localparam int N  = 12;
  localparam int SW = (31 + 3 * N) / 32;
  localparam int EW = (31 + 2 * N) / 32;

  logic        clk = 1'b0;
  logic        rstN;
  logic [N-1:0] txE, rxE, ovE;
  logic        wrEn, rdEn;
  logic [7:0]  addr;
  logic [31:0] wData;
  logic [31:0] rData;
  logic        irq;

  ring_irq_agg #(.NUM_CH(N)) dut_i (
    .clk(clk), .rstN(rstN), .txDoneEvt(txE), .rxDoneEvt(rxE), .rxOvfEvt(ovE),
    .regWrEn(wrEn), .regRdEn(rdEn), .regAddr(addr), .regWrData(wData),
    .regRdData(rData), .irq(irq)
  );

  always #5 clk = ~clk;

  // Behavioural reference state
  bit st[3*N];
  bit enb[2*N];
  bit seen[SW];
  bit autoC;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic modelReset();
    foreach (st[i]) st[i] = 0;
    foreach (enb[i]) enb[i] = 0;
    foreach (seen[i]) seen[i] = 1;
    autoC = 0;
  endtask

  function automatic logic [31:0] statWord(int w);
    logic [31:0] v = '0;
    for (int k = 0; k < 32; k++) if (32*w + k < 3*N) v[k] = st[32*w + k];
    return v;
  endfunction

  function automatic logic [31:0] enWord(int j);
    logic [31:0] v = '0;
    for (int k = 0; k < 32; k++) if (32*j + k < 2*N) v[k] = enb[32*j + k];
    return v;
  endfunction

  function automatic bit modelPending();
    bit p = 0;
    for (int c = 0; c < N; c++)
      if ((st[c] && enb[N+c]) || (st[N+c] && enb[c]) || (st[2*N+c] && enb[c])) p = 1;
    return p;
  endfunction

  task automatic clearIn();
    txE = '0; rxE = '0; ovE = '0; wrEn = 0; rdEn = 0; addr = '0; wData = '0;
  endtask

  // One cycle: inputs already driven after a falling edge
  task automatic cyc(input string tag);
    logic [31:0] expRd;
    bit armed, expIrq, rdStat;
    int a;
    #1;
    armed = 1;
    foreach (seen[i]) if (!seen[i]) armed = 0;
    expIrq = armed && modelPending();
    a = int'(addr);
    rdStat = rdEn && (a < SW);
    expRd = '0;
    if (rdEn) begin
      if (a < SW) expRd = statWord(a);
      else if (a >= 'h40 && a < 'h40 + EW) expRd = enWord(a - 'h40);
      else if (a == 'h80) expRd = {31'd0, autoC};
      else if (a == 'h81) expRd = 32'(N);
    end
    checks += 2;
    if (rData !== expRd) begin
      errors++;
      $display("FAIL %s: read addr %0h got %08h expected %08h", tag, a, rData, expRd);
    end
    if (irq !== expIrq) begin
      errors++;
      $display("FAIL %s: irq got %0b expected %0b", tag, irq, expIrq);
    end
    // next state
    for (int i = 0; i < 3*N; i++) begin
      bit clr, ev;
      clr = (rdStat && (i / 32 == a)) || (expIrq && autoC);
      ev = (i < N) ? txE[i] : (i < 2*N) ? rxE[i-N] : ovE[i-2*N];
      st[i] = (clr ? 1'b0 : st[i]) | ev;
    end
    if (expIrq && !autoC) foreach (seen[i]) seen[i] = 0;
    else if (rdStat) seen[a] = 1;
    if (wrEn) begin
      if (a >= 'h40 && a < 'h40 + EW)
        for (int k = 0; k < 32; k++) if ((a - 'h40)*32 + k < 2*N) enb[(a - 'h40)*32 + k] = wData[k];
      if (a == 'h80) autoC = wData[0];
    end
    @(negedge clk);
    clearIn();
  endtask

  task automatic rd(input int a, input string tag);
    rdEn = 1; addr = 8'(a); cyc(tag);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    wrEn = 1; addr = 8'(a); wData = d; cyc(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish();
  end

  initial begin
    clearIn();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    modelReset();

    // R1 reset state
    rd('h00, "R1"); rd('h01, "R1"); rd('h40, "R1"); rd('h80, "R1"); idle(2, "R1");

    // R9 info, unmapped, ignored status writes
    rd('h81, "R9"); rd('h90, "R9"); rd('hC0, "R9");
    wr('h00, 32'hFFFF_FFFF, "R9"); rd('h00, "R9");

    // R2 packing across the word boundary
    txE[3] = 1; cyc("R2"); rd('h00, "R2");
    ovE[11] = 1; cyc("R2"); rxE[5] = 1; cyc("R2");
    rd('h01, "R2"); rd('h00, "R2");
    ovE[0] = 1; cyc("R2"); rd('h00, "R2"); rd('h00, "R2");

    // R3 destructive read of one word only
    txE[1] = 1; ovE[10] = 1; cyc("R3");
    rd('h00, "R3"); rd('h01, "R3"); rd('h01, "R3");

    // R4 event during read of its word
    txE[2] = 1; cyc("R4");
    txE[7] = 1; rd('h00, "R4"); rd('h00, "R4");

    // R5 enable layout and bounds
    wr('h40, 32'hFFFF_FFFF, "R5"); rd('h40, "R5");
    wr('h41, 32'hFFFF_FFFF, "R5"); rd('h41, "R5");

    // R6 enable selection, overflow follows receive enable
    wr('h40, 32'h0000_0010, "R6");
    txE[4] = 1; cyc("R6"); idle(2, "R6");
    ovE[4] = 1; cyc("R6"); idle(3, "R6");

    // R7 rearm needs every word read
    rd('h00, "R7"); idle(2, "R7"); rd('h01, "R7"); idle(2, "R7");
    wr('h40, 32'h0000_0200, "R7");
    ovE[9] = 1; cyc("R7"); idle(2, "R7");
    rd('h01, "R7"); ovE[9] = 1; cyc("R7"); idle(2, "R7");
    rd('h00, "R7"); idle(3, "R7");
    rd('h01, "R7"); rd('h00, "R7"); idle(2, "R7");

    // R8 auto-clear mode
    wr('h80, 32'h1, "R8"); rd('h80, "R8");
    ovE[9] = 1; cyc("R8"); idle(2, "R8");
    ovE[9] = 1; cyc("R8"); idle(2, "R8");
    rd('h01, "R8");
    wr('h80, 32'h0, "R8");

    // Mixed pseudo-random traffic (R3 R4 R6 R7 R8)
    for (int n = 0; n < 6000; n++) begin
      int r;
      for (int c = 0; c < N; c++) begin
        txE[c] = ($urandom_range(0, 23) == 0);
        rxE[c] = ($urandom_range(0, 23) == 0);
        ovE[c] = ($urandom_range(0, 47) == 0);
      end
      r = $urandom_range(0, 9);
      if (r < 4) begin
        rdEn = 1;
        case ($urandom_range(0, 4))
          0: addr = 8'h00;
          1: addr = 8'h01;
          2: addr = 8'h40;
          3: addr = 8'h80;
          default: addr = 8'h81;
        endcase
      end else if (r == 4 && $urandom_range(0, 3) == 0) begin
        wrEn = 1;
        if ($urandom_range(0, 2) == 0) begin addr = 8'h80; wData = 32'($urandom_range(0, 1)); end
        else begin addr = 8'h40; wData = $urandom; end
      end
      cyc("R6");
    end

    finish();
  end
endmodule